// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps a 512-row dynamic memory alive. Out of reset it holds every strobe inactive for a programmable power-up wait, then runs a fixed burst of wake-up strobe cycles without asking anyone. Once that burst is over it raises `init_done`, and the neighbouring access controller may begin normal traffic.

From then on an interval counter adds one owed refresh every retention period divided by the row count. The total is kept in a saturating tally. While anything is owed and the sequencer is idle, it raises `ref_req`. The access controller answers with `ref_gnt` only when it has no row open. Each grant buys exactly one strobe cycle.

The cycle can take one of two forms. In the first, the device counts the rows itself: CAS falls first and RAS follows. In the second, the sequencer drives the row address from its own counter, strobes RAS and leaves CAS high. A mode input selects the form, and it is sampled at the start of every cycle. Clock rate, intervals and strobe widths are all parameters.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, and until the first strobe, `ras_n`=1, `cas_n`=1, `busy`=1, `init_done`=0 and `ref_req`=0. The first strobe activity appears PWRUP_CYC clocks after reset is released: CAS in device-counted mode, RAS T_CSR clocks later in row-driven mode.
- R2: After the power-up wait, exactly INIT_CYC strobe cycles run back to back with no grant, each in the form chosen by `mode_ras_only`. `init_done` then rises once the last recovery has ended, and it stays high until reset.
- R3: A device-counted cycle (`mode_ras_only`=0 at its start) drives CAS low for T_CSR clocks before RAS falls. CAS stays low for the first T_CHR clocks of RAS low and rises while RAS is still low. `addr` reads 0.
- R4: A row-driven cycle (`mode_ras_only`=1) keeps `cas_n` high throughout. It presents the row counter on `addr`, stable while RAS is low.
- R5: Every cycle holds RAS low for T_RAS clocks. After RAS rises, both strobes stay high for at least T_RP clocks before any further strobe.
- R6: After `init_done`, one refresh is owed every TICK_CYC = RETAIN_CYC / 512 clocks, the first TICK_CYC clocks after `init_done` is first visible. `ref_req` is high only when `init_done` is set, the sequencer is idle and at least one refresh is owed.
- R7: After initialization, a cycle starts only on a clock edge where both `ref_req` and `ref_gnt` are high. While `ref_gnt` stays low, `ras_n` stays high.
- R8: The owed tally saturates at PEND_MAX. Ticks beyond that are dropped, so a later grant yields exactly PEND_MAX cycles.
- R9: When a tick and a cycle start fall on the same edge, the tally keeps its value: one added, one taken.
- R10: The row counter steps by one after each row-driven cycle, including those in the burst, which start at row 0. It wraps from 511 to 0 and does not move on device-counted cycles.
- R11: `busy` is high whenever RAS is low. After initialization it falls to 0 once a cycle's recovery has ended.
- R12: Changing `mode_ras_only` during a cycle does not alter that cycle. The next cycle takes the new form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ras_only | input | 1 | 1: row-driven refresh, 0: device-counted refresh |
| ref_gnt | input | 1 | Grant from the access controller, given only with no row open |
| ref_req | output | 1 | Refresh request to the access controller |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low (one byte lane) |
| addr | output | ROW_W | Row address during row-driven cycles, else 0 |
| busy | output | 1 | Initialization or a refresh cycle is in progress |
| init_done | output | 1 | Power-up wait and wake-up burst are complete |

## Verification
Two functions can land on the same edge: the interval tick adding a refresh, and a granted cycle start taking one away. The bench locates a tick exactly through the first rise of `ref_req` after `init_done`. It then raises `ref_gnt` so that the start falls one full tick period later, on the next tick. It judges the result at the ports by counting RAS falls before the following tick: exactly two must appear, and a lost increment shows as one. A saturation run and a mid-cycle mode change exercise the other overlapping updates.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_SETUP,
    ST_ACT,
    ST_RECOV
  } seq_state_e;

  // microseconds to clock cycles, rounded up so waits are never short
  function automatic int us_to_cycles(input int us, input int clk_khz);
    return (us * clk_khz + 999) / 1000;
  endfunction

  // spacing of refresh ticks, rounded down so every row is met in time
  function automatic int tick_spacing(input int retain_cyc, input int rows);
    return retain_cyc / rows;
  endfunction

  // width of a counter that must hold the value n
  function automatic int width_for(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/drs_tick_gen.sv
module drs_tick_gen
  import drs_pkg::*;
#(
  parameter int TICK_CYC = 64,
  parameter int PEND_MAX = 8,
  parameter int PEND_W   = width_for(PEND_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              consume,
  output logic              tick,
  output logic [PEND_W-1:0] pend,
  output logic              pending
);
  localparam int TW = width_for(TICK_CYC);
  localparam logic [TW-1:0]     TICK_LAST = TW'(TICK_CYC - 1);
  localparam logic [PEND_W-1:0] PEND_TOP  = PEND_W'(PEND_MAX);

  logic [TW-1:0] tick_cnt_q;

  always_comb begin
    tick    = en && (tick_cnt_q == TICK_LAST);
    pending = (pend != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt_q <= '0;
    end else if (en) begin
      tick_cnt_q <= tick ? '0 : tick_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else begin
      unique case ({tick, consume})
        2'b10:   if (pend != PEND_TOP) pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

endmodule

// File: rtl/drs_row_ctr.sv
module drs_row_ctr #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (!rst_n) row <= '0;
    else if (adv) row <= row + 1'b1;
  end
endmodule

// File: rtl/drs_strobe_fsm.sv
module drs_strobe_fsm
  import drs_pkg::*;
#(
  parameter int PWRUP_CYC = 20000,
  parameter int INIT_CYC  = 8,
  parameter int T_CSR     = 2,
  parameter int T_CHR     = 2,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_ras_only,
  input  logic pending,
  input  logic ref_gnt,
  output logic ras_n,
  output logic cas_n,
  output logic drive_row,
  output logic cyc_start,
  output logic row_adv,
  output logic cyc_rasonly,
  output logic init_done,
  output logic busy,
  output logic ref_req
);
  localparam int CNT_W  = width_for(PWRUP_CYC + T_CSR + T_RAS + T_RP);
  localparam int INIT_W = width_for(INIT_CYC);
  localparam logic [CNT_W-1:0]  LD_PWR   = CNT_W'(PWRUP_CYC - 1);
  localparam logic [CNT_W-1:0]  LD_SET   = CNT_W'(T_CSR - 1);
  localparam logic [CNT_W-1:0]  LD_ACT   = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0]  LD_RP    = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0]  CAS_EDGE = CNT_W'(T_RAS - T_CHR);
  localparam logic [INIT_W-1:0] INIT_TOP = INIT_W'(INIT_CYC - 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [INIT_W-1:0] init_cnt_q;
  logic              done_q;
  logic              mode_q;
  logic              phase_end;
  logic              last_init;

  always_comb begin
    phase_end   = (cnt_q == '0);
    last_init   = (init_cnt_q == INIT_TOP);
    ref_req     = done_q && (state_q == ST_IDLE) && pending;
    cyc_start   = ((state_q == ST_PWRUP) && phase_end)
               || (ref_req && ref_gnt)
               || ((state_q == ST_RECOV) && phase_end && !done_q && !last_init);
    row_adv     = (state_q == ST_ACT) && phase_end && mode_q;
    ras_n       = (state_q != ST_ACT);
    cas_n       = !(!mode_q && ((state_q == ST_SETUP) ||
                                ((state_q == ST_ACT) && (cnt_q >= CAS_EDGE))));
    drive_row   = mode_q && ((state_q == ST_SETUP) || (state_q == ST_ACT));
    busy        = !done_q || (state_q != ST_IDLE);
    init_done   = done_q;
    cyc_rasonly = mode_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_PWRUP;
      cnt_q      <= LD_PWR;
      init_cnt_q <= '0;
      done_q     <= 1'b0;
      mode_q     <= 1'b0;
    end else begin
      if (cyc_start) mode_q <= mode_ras_only;
      unique case (state_q)
        ST_PWRUP: begin
          if (phase_end) begin
            state_q <= ST_SETUP;
            cnt_q   <= LD_SET;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_IDLE: begin
          if (cyc_start) begin
            state_q <= ST_SETUP;
            cnt_q   <= LD_SET;
          end
        end
        ST_SETUP: begin
          if (phase_end) begin
            state_q <= ST_ACT;
            cnt_q   <= LD_ACT;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_ACT: begin
          if (phase_end) begin
            state_q <= ST_RECOV;
            cnt_q   <= LD_RP;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_RECOV: begin
          if (!phase_end) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (done_q) begin
            state_q <= ST_IDLE;
          end else if (last_init) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            init_cnt_q <= init_cnt_q + 1'b1;
            state_q    <= ST_SETUP;
            cnt_q      <= LD_SET;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import drs_pkg::*;
#(
  parameter int CLK_KHZ   = 100000,
  parameter int PWRUP_US  = 200,
  parameter int RETAIN_US = 8000,
  parameter int ROW_W     = 9,
  parameter int INIT_CYC  = 8,
  parameter int T_CSR     = 2,
  parameter int T_CHR     = 2,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 3,
  parameter int PEND_MAX  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_ras_only,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] addr,
  output logic             busy,
  output logic             init_done
);
  localparam int ROWS       = 1 << ROW_W;
  localparam int PWRUP_CYC  = us_to_cycles(PWRUP_US, CLK_KHZ);
  localparam int RETAIN_CYC = us_to_cycles(RETAIN_US, CLK_KHZ);
  localparam int TICK_CYC   = tick_spacing(RETAIN_CYC, ROWS);
  localparam int PEND_W     = width_for(PEND_MAX);

  // named internal events, also observed by the bound checker
  logic              tick;
  logic [PEND_W-1:0] pend_cnt;
  logic              pending;
  logic              cyc_start;
  logic              row_adv;
  logic              cyc_rasonly;
  logic              drive_row;
  logic [ROW_W-1:0]  row_q;

  drs_tick_gen #(
    .TICK_CYC (TICK_CYC),
    .PEND_MAX (PEND_MAX),
    .PEND_W   (PEND_W)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (init_done),
    .consume (cyc_start && init_done),
    .tick    (tick),
    .pend    (pend_cnt),
    .pending (pending)
  );

  drs_row_ctr #(
    .ROW_W (ROW_W)
  ) u_row (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (row_adv),
    .row   (row_q)
  );

  drs_strobe_fsm #(
    .PWRUP_CYC (PWRUP_CYC),
    .INIT_CYC  (INIT_CYC),
    .T_CSR     (T_CSR),
    .T_CHR     (T_CHR),
    .T_RAS     (T_RAS),
    .T_RP      (T_RP)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_ras_only (mode_ras_only),
    .pending       (pending),
    .ref_gnt       (ref_gnt),
    .ras_n         (ras_n),
    .cas_n         (cas_n),
    .drive_row     (drive_row),
    .cyc_start     (cyc_start),
    .row_adv       (row_adv),
    .cyc_rasonly   (cyc_rasonly),
    .init_done     (init_done),
    .busy          (busy),
    .ref_req       (ref_req)
  );

  assign addr = drive_row ? row_q : '0;

endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
  parameter int ROW_W    = 9,
  parameter int PEND_MAX = 8,
  parameter int PEND_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              busy,
  input logic              ref_req,
  input logic              ref_gnt,
  input logic              init_done,
  input logic              cyc_start,
  input logic              cyc_rasonly,
  input logic              row_adv,
  input logic              tick,
  input logic [ROW_W-1:0]  row,
  input logic [PEND_W-1:0] pend
);
  a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cyc_rasonly) |-> (!cas_n && $past(!cas_n)));

  a_r4_rasonly_cas_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && cyc_rasonly) |-> cas_n);

  a_r6_req_needs_debt: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> (init_done && (pend != '0)));

  a_r7_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && init_done) |-> (ref_gnt && ref_req));

  a_r8_pend_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PEND_W'(PEND_MAX));

  a_r9_tick_meets_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cyc_start && init_done) |=> (pend == $past(pend)));

  a_r10_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    row_adv |=> (row == ROW_W'($past(row) + 1'b1)));

  a_r11_busy_when_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> busy);
endmodule

bind dram_refresh_seq dram_refresh_chk #(
  .ROW_W    (ROW_W),
  .PEND_MAX (PEND_MAX),
  .PEND_W   (PEND_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .busy        (busy),
  .ref_req     (ref_req),
  .ref_gnt     (ref_gnt),
  .init_done   (init_done),
  .cyc_start   (cyc_start),
  .cyc_rasonly (cyc_rasonly),
  .row_adv     (row_adv),
  .tick        (tick),
  .row         (row_q),
  .pend        (pend_cnt)
);

// File: tb/dram_refresh_seq_bench.sv
module dram_refresh_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_KHZ    = 1000;
  localparam int PWRUP_US   = 20;
  localparam int RETAIN_US  = 32768;
  localparam int ROW_W      = 9;
  localparam int INIT_CYC   = 8;
  localparam int T_CSR      = 2;
  localparam int T_CHR      = 2;
  localparam int T_RAS      = 4;
  localparam int T_RP       = 3;
  localparam int PEND_MAX   = 4;
  // independent restatement: 1 MHz clock, so microseconds equal cycles
  localparam int PWRUP      = PWRUP_US;
  localparam int TICK       = RETAIN_US / 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic gnt = 1'b0;
  logic ref_req, ras_n, cas_n, busy, init_done;
  logic [ROW_W-1:0] addr;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  int n_done = 0;
  int n0 = 0;

  dram_refresh_seq #(
    .CLK_KHZ (CLK_KHZ), .PWRUP_US (PWRUP_US), .RETAIN_US (RETAIN_US),
    .ROW_W (ROW_W), .INIT_CYC (INIT_CYC), .T_CSR (T_CSR), .T_CHR (T_CHR),
    .T_RAS (T_RAS), .T_RP (T_RP), .PEND_MAX (PEND_MAX)
  ) u_dram_refresh_seq (
    .clk (clk), .rst_n (rst_n), .mode_ras_only (mode), .ref_gnt (gnt),
    .ref_req (ref_req), .ras_n (ras_n), .cas_n (cas_n), .addr (addr),
    .busy (busy), .init_done (init_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    rst_n = 1'b0; mode = m; gnt = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R1 strobes idle in reset", {ras_n, cas_n}, 3);
    chk_eq("R1 busy/done/req in reset", {busy, init_done, ref_req}, 4);
    rst_n = 1'b1;
  endtask

  task automatic first_activity(input int expect_idx);
    int idx = 0;
    do begin
      @(negedge clk); idx++;
    end while (ras_n && cas_n && idx < 100000);
    chk_eq("R1 power-up wait length", idx, expect_idx);
  endtask

  task automatic measure_cycle(input int maxgap, output int pre, output int low,
                               output int hold, output int gap, output int a,
                               output bit stable, output bit busy_ok);
    pre = 0; low = 0; hold = 0; gap = 0; stable = 1; busy_ok = 1;
    while (ras_n && cas_n) @(negedge clk);
    while (ras_n) begin
      if (!cas_n) pre++;
      @(negedge clk);
    end
    a = int'(addr);
    while (!ras_n) begin
      low++;
      if (!cas_n) hold++;
      if (int'(addr) != a) stable = 0;
      if (!busy) busy_ok = 0;
      @(negedge clk);
    end
    while (ras_n && cas_n && gap < maxgap) begin
      gap++;
      @(negedge clk);
    end
  endtask

  task automatic count_falls(input int n, output int falls, output int bad_busy);
    logic prev = ras_n;
    falls = 0; bad_busy = 0;
    repeat (n) begin
      @(negedge clk);
      if (prev && !ras_n) falls++;
      if (!ras_n && !busy) bad_busy++;
      prev = ras_n;
    end
  endtask

  // wake-up in device-counted mode and the first tick
  task automatic test_init_cbr();
    int pre, low, hold, gap, a;
    bit st, bo;
    do_reset(1'b0);
    first_activity(PWRUP);
    for (int i = 0; i < INIT_CYC; i++) begin
      measure_cycle((i == INIT_CYC-1) ? T_RP+1 : 1000, pre, low, hold, gap, a, st, bo);
      chk_eq("R3 CAS setup before RAS", pre, T_CSR);
      chk_eq("R3 CAS hold after RAS", hold, T_CHR);
      chk_eq("R5 RAS low width", low, T_RAS);
      chk_eq("R3 addr zero in CBR", a, 0);
      chk_eq("R11 busy while RAS low", int'(bo), 1);
      if (i < INIT_CYC-1) begin
        chk_eq("R5 precharge before next CAS", gap, T_RP);
        chk_eq("R2 init_done low during burst", int'(init_done), 0);
      end
    end
    chk_eq("R2 init_done after burst", int'(init_done), 1);
    chk_eq("R11 busy drops after burst", int'(busy), 0);
    chk_eq("R6 no request at init end", int'(ref_req), 0);
    n_done = cyc - 1;
    while (!ref_req && cyc < n_done + 10*TICK) @(negedge clk);
    chk_eq("R6 first tick spacing", cyc - n_done, TICK);
    n0 = cyc;
  endtask

  // a granted start coinciding with the next tick
  task automatic test_collision();
    int falls, bb;
    repeat (TICK-1) @(negedge clk);
    chk_eq("R7 no RAS without grant", int'(ras_n), 1);
    gnt = 1'b1;
    count_falls(40, falls, bb);
    chk_eq("R9 tick on start edge keeps debt", falls, 2);
    chk_eq("R11 busy during RAS", bb, 0);
    gnt = 1'b0;
  endtask

  task automatic test_saturation();
    int lows = 0;
    int falls, bb;
    while (cyc < n0 + (PEND_MAX+3)*TICK + 3) begin
      @(negedge clk);
      if (!ras_n) lows++;
    end
    chk_eq("R7 RAS idle while grant low", lows, 0);
    chk_eq("R6 request while owed", int'(ref_req), 1);
    chk_eq("R11 idle not busy", int'(busy), 0);
    gnt = 1'b1;
    count_falls(50, falls, bb);
    chk_eq("R8 saturated debt drained", falls, PEND_MAX);
    gnt = 1'b0;
    chk_eq("R11 busy low after drain", int'(busy), 0);
    chk_eq("R6 request low after drain", int'(ref_req), 0);
  endtask

  // row-driven mode: burst, full wrap, mode change mid-cycle
  task automatic test_ras_only();
    int pre, low, hold, gap, a;
    bit st, bo;
    int bad = 0;
    do_reset(1'b1);
    first_activity(PWRUP + T_CSR);
    for (int i = 0; i < INIT_CYC; i++) begin
      measure_cycle((i == INIT_CYC-1) ? T_RP+1 : 1000, pre, low, hold, gap, a, st, bo);
      chk_eq("R4 CAS high in RAS-only", pre + hold, 0);
      chk_eq("R10 burst row", a, i);
      chk_eq("R4 addr stable", int'(st), 1);
      chk_eq("R5 RAS low width", low, T_RAS);
      if (i < INIT_CYC-1) chk_eq("R5 gap incl. addr setup", gap, T_RP + T_CSR);
    end
    chk_eq("R2 init_done after RAS-only burst", int'(init_done), 1);
    gnt = 1'b1;
    for (int k = INIT_CYC; k <= 520; k++) begin
      measure_cycle(1000, pre, low, hold, gap, a, st, bo);
      if (a != (k % 512) || pre != 0 || hold != 0 || !st) bad++;
    end
    chk_eq("R10 row sequence and wrap", bad, 0);
    while (ras_n) @(negedge clk);
    chk_eq("R10 row after wrap", int'(addr), 9);
    mode = 1'b0;
    hold = 0;
    while (!ras_n) begin
      if (!cas_n) hold++;
      @(negedge clk);
    end
    chk_eq("R12 mode change ignored mid-cycle", hold, 0);
    while (ras_n && cas_n) @(negedge clk);
    mode = 1'b1;
    pre = 0;
    while (ras_n) begin
      if (!cas_n) pre++;
      @(negedge clk);
    end
    chk_eq("R12 next cycle uses new mode", pre, T_CSR);
    while (!ras_n) @(negedge clk);
    measure_cycle(1000, pre, low, hold, gap, a, st, bo);
    chk_eq("R10 counter still on CBR cycle", a, 10);
    chk_eq("R4 CAS high again", pre + hold, 0);
    gnt = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    test_init_cbr();
    test_collision();
    test_saturation();
    test_ras_only();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule